// File: doc/BRIEF.md
# Rising-Edge Phase-Frequency Detector with Three-State Drive

This block compares a reference input against a feedback input and produces the control for a charge pump. Both inputs are asynchronous square-ish waves; inside the block each passes through a synchroniser and a rising-edge detector clocked by the system clock. Only rising edges matter. The high and low widths of either input have no effect on the result.

The detector works as a small up/down state machine built from two capture flops. A reference edge sets the "up" flop and a feedback edge sets the "down" flop. When both are set, they clear together on the next clock. The outputs are a source enable (`up_o`), a sink enable (`dn_o`), a drive-enable flag that is high whenever either drive is on, and a lock flag that is high while neither drive is on. When the drive-enable flag is low, the charge-pump node floats (high impedance).

Once the two inputs agree in phase and frequency, the output floats for almost the whole cycle and the lock flag stays high. A leading reference produces a source pulse as long as the phase error. A lagging reference produces a sink pulse as long as the phase error. A frequency error holds one drive on for most of the time. The analog filter, the oscillator and any feedback divider sit outside this block.

Top module: `phase_freq_det`

## Requirements
- R1: While `rst_n` is low, and after reset until the first input edge, `up_o`=0, `dn_o`=0, `drive_en_o`=0 and `lock_o`=1.
- R2: Only rising transitions of `ref_in` and `fb_in` act on the detector. Falling transitions, and levels held constant, never turn a drive on.
- R3: A rising edge on `ref_in` that is set up before clock edge k, with no pending feedback edge, makes `up_o` high after clock edge k+2. If the feedback rising edge follows d cycles later, `up_o` stays high for exactly d cycles.
- R4: With the roles swapped (the feedback edge comes first and the reference edge d cycles later), `dn_o` is high for exactly d cycles, with the same two-cycle latency.
- R5: `up_o` and `dn_o` are never high together. Rising edges that reach both inputs in the same cycle turn on no drive.
- R6: With no reference edges, the first feedback edge turns `dn_o` on and `dn_o` stays on continuously. A later reference edge clears it.
- R7: When the reference frequency is higher than the feedback frequency, `up_o` is high for more cycles than `dn_o`. When it is lower, `dn_o` is high for more cycles than `up_o`.
- R8: `drive_en_o` equals `up_o` OR `dn_o`, and `lock_o` equals NOT `drive_en_o`, in every cycle.
- R9: The width of a drive pulse depends only on the spacing of the two rising edges, not on how long either input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference input, asynchronous |
| fb_in | input | 1 | Feedback input, asynchronous |
| up_o | output | 1 | Source (up) drive enable |
| dn_o | output | 1 | Sink (down) drive enable |
| drive_en_o | output | 1 | High when either drive is on; low means high impedance |
| lock_o | output | 1 | High while neither drive is on |

## Verification
A capture flop stuck set or cleared shows at the ports within three clock cycles of the next input edge. It appears either as a drive pulse whose length differs from the edge spacing, or as a lock flag that never returns high. A broken edge detector shows up as drive pulses caused by falling transitions or by long high levels, and as pulse widths that change with duty cycle. Faulty clearing logic shows up as overlapping or stuck drives after coincident edges. The bench sweeps the edge spacing in both orders and compares each measured pulse count with the spacing.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Next value of a capture flop: a new edge sets it, the joint clear empties it.
  function automatic logic cap_next(input logic q, input logic rise, input logic clr);
    return (q & ~clr) | rise;
  endfunction

  // Both flops set means the edges have met: clear them together.
  function automatic logic joint_clear(input logic up_q, input logic dn_q);
    return up_q & dn_q;
  endfunction
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[LAST];
  end

  assign rise_o = chain[LAST] & ~prev_q;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic up_q,
  output logic dn_q
);
  logic clr;

  assign clr = joint_clear(up_q, dn_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= cap_next(up_q, ref_rise, clr);
      dn_q <= cap_next(dn_q, fb_rise, clr);
    end
  end

  // R5
  joint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q && !ref_rise && !fb_rise) |=> (!up_q && !dn_q));
  // R3
  up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !dn_q && !fb_rise) |=> (up_q && !dn_q));
  // R4
  dn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise && !up_q) |=> (dn_q && !up_q));
  // R6
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_q && !up_q && !ref_rise) |=> dn_q);
endmodule

// File: rtl/pfd_drive.sv
module pfd_drive (
  input  logic up_q,
  input  logic dn_q,
  output logic up_o,
  output logic dn_o,
  output logic drive_en_o,
  output logic lock_o
);
  // The cycle in which both flops are set is masked so that both drives stay off.
  assign up_o       = up_q & ~dn_q;
  assign dn_o       = dn_q & ~up_q;
  assign drive_en_o = up_o | dn_o;
  assign lock_o     = ~drive_en_o;
endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic up_o,
  output logic dn_o,
  output logic drive_en_o,
  output logic lock_o
);
  logic ref_rise, fb_rise;
  logic up_q, dn_q;

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ref_in), .rise_o(ref_rise));
  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
    .clk(clk), .rst_n(rst_n), .async_in(fb_in), .rise_o(fb_rise));

  pfd_core u_core (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
    .up_q(up_q), .dn_q(dn_q));

  pfd_drive u_drive (
    .up_q(up_q), .dn_q(dn_q), .up_o(up_o), .dn_o(dn_o),
    .drive_en_o(drive_en_o), .lock_o(lock_o));

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o));
  // R3
  up_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise && !dn_q) |=> up_o);
endmodule

// File: tb/phase_freq_det_tb.sv
module phase_freq_det_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic up_o, dn_o, drive_en_o, lock_o;
  int checks = 0;
  int fails = 0;
  int up_cnt, dn_cnt, both_cnt, flag_bad;

  always #4 clk = ~clk;

  phase_freq_det u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .up_o(up_o), .dn_o(dn_o), .drive_en_o(drive_en_o), .lock_o(lock_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    ref_in = 1'b0; fb_in = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Sample the outputs first, then drive the inputs, at each falling clock edge.
  task automatic sample();
    if (up_o) up_cnt++;
    if (dn_o) dn_cnt++;
    if (up_o && dn_o) both_cnt++;
    if (drive_en_o != (up_o | dn_o) || lock_o != !(up_o | dn_o)) flag_bad++;
  endtask

  task automatic clr_cnt();
    up_cnt = 0; dn_cnt = 0; both_cnt = 0; flag_bad = 0;
  endtask

  // One rising edge on each input: ref at step ra, fb at step fa, each held hw steps.
  task automatic edge_pair(input int ra, input int fa, input int rhw, input int fhw);
    clr_cnt();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      sample();
      ref_in = (i >= ra && i < ra + rhw);
      fb_in  = (i >= fa && i < fa + fhw);
    end
  endtask

  // Periodic inputs; a period of 0 keeps that input low.
  task automatic periodic(input int rp, input int fp, input int len);
    clr_cnt();
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      sample();
      ref_in = (rp > 0) && ((i % rp) < rp / 2);
      fb_in  = (fp > 0) && ((i % fp) < fp / 2);
    end
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    #1;
    check("R1 up in reset", up_o, 0);
    check("R1 lock in reset", lock_o, 1);
    do_reset();
    repeat (5) @(negedge clk);
    check("R1 up after reset", up_o, 0);
    check("R1 dn after reset", dn_o, 0);
    check("R1 drive_en after reset", drive_en_o, 0);
    check("R1 lock after reset", lock_o, 1);

    // R3 latency: the ref edge is set at a falling edge; up appears at the third falling edge.
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk); check("R3 latency step1", up_o, 0);
    @(negedge clk); check("R3 latency step2", up_o, 0);
    @(negedge clk); check("R3 latency step3", up_o, 1);
    fb_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 cleared after fb edge", up_o, 0);
    ref_in = 0; fb_in = 0;

    // R3/R4/R5/R8 sweep of the edge spacing in both orders
    for (int d = 0; d <= 10; d++) begin
      do_reset();
      edge_pair(5, 5 + d, 3, 3);
      check($sformatf("R3 up width d=%0d", d), up_cnt, d);
      check($sformatf("R3 no dn d=%0d", d), dn_cnt, 0);
      check("R5 overlap", both_cnt, 0);
      check("R8 flags", flag_bad, 0);
      do_reset();
      edge_pair(5 + d, 5, 3, 3);
      check($sformatf("R4 dn width d=%0d", d), dn_cnt, d);
      check($sformatf("R4 no up d=%0d", d), up_cnt, 0);
      check("R5 overlap lag", both_cnt, 0);
    end

    // R9: pulse width independent of high time
    for (int hw = 1; hw <= 9; hw += 4) begin
      do_reset();
      edge_pair(4, 9, hw, 13 - hw);
      check($sformatf("R9 up width hw=%0d", hw), up_cnt, 5);
      do_reset();
      edge_pair(9, 4, 13 - hw, hw);
      check($sformatf("R9 dn width hw=%0d", hw), dn_cnt, 5);
    end

    // R2: coincident rise, then falling transitions and held levels do nothing
    do_reset();
    clr_cnt();
    @(negedge clk); ref_in = 1; fb_in = 1;
    for (int i = 0; i < 8; i++) begin @(negedge clk); sample(); end
    ref_in = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); sample(); end
    fb_in = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); sample(); end
    check("R2 no up on falls/levels", up_cnt, 0);
    check("R2 no dn on falls/levels", dn_cnt, 0);
    check("R5 coincident no drive", up_cnt + dn_cnt, 0);

    // R6: feedback only, dn stays on from first edge (latency 3 samples)
    do_reset();
    periodic(0, 6, 60);
    check("R6 dn continuous", dn_cnt, 57);
    check("R6 no up", up_cnt, 0);
    @(negedge clk); ref_in = 1;
    repeat (6) @(negedge clk);
    check("R6 ref clears dn", dn_o, 0);
    check("R6 lock after clear", lock_o, 1);

    // R7: frequency error
    do_reset();
    periodic(6, 10, 180);
    check("R7 faster ref: up dominates", int'(up_cnt > dn_cnt), 1);
    check("R5 overlap fast", both_cnt, 0);
    check("R8 flags fast", flag_bad, 0);
    do_reset();
    periodic(10, 6, 180);
    check("R7 slower ref: dn dominates", int'(dn_cnt > up_cnt), 1);
    check("R8 flags slow", flag_bad, 0);

    // R8: locked equal-frequency run keeps lock high
    do_reset();
    periodic(8, 8, 80);
    check("R8 locked no drive", up_cnt + dn_cnt, 0);
    check("R8 locked flags", flag_bad, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule